// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

A master-side helper that frees a two-wire bus after a slave has been left holding the data line low, for example after a reset in the middle of a byte. When asked, it drives the clock line with open-drain style pull-low enables. It samples the data line during every clock high phase. As soon as the data line is seen released, it stops clocking and places a START condition on the bus. From that point the host master can begin a normal transfer.

Clocking is bounded. If the data line is still low after the last allowed clock pulse, the sequencer releases both lines and reports failure without issuing a START. Every interval is counted in prescaler ticks: the low phase, the high phase, the free time before the START and the START hold. Each tick lasts a fixed number of system clock cycles. Clock stretching by a slave is honoured: the high phase only advances while the sensed clock line is actually high.

Top module: `twi_unstick`

## Requirements
- R1: After reset both pull-low enables, `done_o` and `fail_o` are 0.
- R2: A `start_i` pulse sampled while idle, done or failed begins recovery. From the next cycle `scl_pull_o` is 1, `sda_pull_o` is 0, and `done_o` and `fail_o` are 0.
- R3: Each SCL low phase lasts exactly LOW_T*PRESC cycles, and SDA is released throughout it.
- R4: Each SCL high phase lasts HIGH_T*PRESC cycles during which `scl_i` reads 1. Cycles in which a slave holds `scl_i` low add to its length one for one.
- R5: SDA is sampled in the last cycle of each high phase, and the first high sample ends clocking. If the slave frees SDA during high phase k, exactly k low phases are issued. If SDA is already free, one low phase is issued.
- R6: After the releasing sample, both lines stay released for max(SU_T,BUF_T)*PRESC cycles. SDA is then pulled low with SCL released for HD_T*PRESC cycles. After that `done_o` rises, and SDA stays pulled low with SCL released until the next start.
- R7: If SDA is still low at the end of high phase MAX_PULSES (default 9), `fail_o` rises in that cycle's successor. Both lines stay released and no START is generated.
- R8: `start_i` has no effect while a recovery is in progress.
- R9: SDA is never pulled low while SCL is pulled low. SDA only becomes pulled while SCL is released and sensed high.
- R10: A new start clears `done_o` or `fail_o` together with the START drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run a recovery sequence |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | START has been issued; bus owned by the master |
| fail_o | output | 1 | Clock budget used up with SDA still low |

## Verification
Some properties are checked on every cycle. SDA and SCL are never pulled together. Each low phase has its exact length. The START edge only comes after the required free time with SCL high. The done and fail states are exclusive and each holds its line levels. Other behaviour only the scenarios can show. These are how many pulses are issued for a given release point, the cut-off at the last pulse, stretch extension of a high phase, the total sequence length, and immunity to a start request during a run. The bench sweeps every release point from already-free to past the budget, and computes each expected duration from the phase lengths.

// File: rtl/twi_unstick_pkg.sv
package twi_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PRE,
    ST_HOLD,
    ST_DONE,
    ST_FAIL
  } rec_state_e;
endpackage

// File: rtl/twi_unstick_presc.sv
module twi_unstick_presc #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = run_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (run_i)  cnt_q <= (cnt_q == PW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/twi_unstick_timer.sv
module twi_unstick_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/twi_unstick.sv
module twi_unstick
  import twi_unstick_pkg::*;
#(
  parameter int unsigned PRESC      = 2,
  parameter int unsigned LOW_T      = 3,
  parameter int unsigned HIGH_T     = 3,
  parameter int unsigned SU_T       = 4,
  parameter int unsigned BUF_T      = 3,
  parameter int unsigned HD_T       = 2,
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned PRE_T = (SU_T > BUF_T) ? SU_T : BUF_T;
  localparam int unsigned MAX_A = (LOW_T > HIGH_T) ? LOW_T : HIGH_T;
  localparam int unsigned MAX_B = (PRE_T > HD_T) ? PRE_T : HD_T;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam int unsigned PW    = $clog2(MAX_PULSES + 1);

  rec_state_e    state_q, state_d;
  logic [PW-1:0] pulse_q;
  logic          load;
  logic [TW-1:0] load_val;
  logic          run, tick, zero, expire, accept;

  // high phase only advances while the line is really high (stretch)
  assign run    = (state_q == ST_HIGH) ? scl_i : 1'b1;
  assign expire = tick && zero;
  assign accept = start_i &&
                  (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);

  twi_unstick_presc #(.DIV(PRESC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .run_i  (run),
    .tick_o (tick)
  );

  twi_unstick_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (tick),
    .zero_o     (zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (accept) begin
          state_d  = ST_LOW;
          load     = 1'b1;
          load_val = TW'(LOW_T - 1);
        end
      end
      ST_LOW: begin
        if (expire) begin
          state_d  = ST_HIGH;
          load     = 1'b1;
          load_val = TW'(HIGH_T - 1);
        end
      end
      ST_HIGH: begin
        if (expire) begin
          if (sda_i) begin
            state_d  = ST_PRE;
            load     = 1'b1;
            load_val = TW'(PRE_T - 1);
          end else if (pulse_q == PW'(MAX_PULSES - 1)) begin
            state_d  = ST_FAIL;
          end else begin
            state_d  = ST_LOW;
            load     = 1'b1;
            load_val = TW'(LOW_T - 1);
          end
        end
      end
      ST_PRE: begin
        if (expire) begin
          state_d  = ST_HOLD;
          load     = 1'b1;
          load_val = TW'(HD_T - 1);
        end
      end
      ST_HOLD: begin
        if (expire) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept)                           pulse_q <= '0;
      else if (state_q == ST_HIGH && expire) pulse_q <= pulse_q + 1'b1;
    end
  end

  assign scl_pull_o = (state_q == ST_LOW);
  assign sda_pull_o = (state_q == ST_HOLD) || (state_q == ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = (state_q == ST_FAIL);
endmodule

// File: rtl/twi_unstick_chk.sv
module twi_unstick_chk #(
  parameter int unsigned PRESC = 2,
  parameter int unsigned LOW_T = 3,
  parameter int unsigned SU_T  = 4,
  parameter int unsigned BUF_T = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic done_o,
  input logic fail_o
);
  localparam int unsigned LOW_CYC = LOW_T * PRESC;
  localparam int unsigned PRE_CYC = ((SU_T > BUF_T) ? SU_T : BUF_T) * PRESC;

  logic [15:0] low_run, free_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= '0;
      free_run <= '0;
    end else begin
      low_run <= scl_pull_o ? low_run + 1'b1 : '0;
      if (!scl_pull_o && !sda_pull_o && scl_i && sda_i)
        free_run <= (free_run == 16'hffff) ? free_run : free_run + 1'b1;
      else
        free_run <= '0;
    end
  end

  assert_low_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_pull_o) |-> (low_run == 16'(LOW_CYC)));

  assert_no_double_pull_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_pull_o && sda_pull_o));

  assert_start_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> (!scl_pull_o && scl_i));

  assert_start_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> (free_run >= 16'(PRE_CYC)));

  assert_done_lines_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sda_pull_o && !scl_pull_o));

  assert_fail_lines_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!sda_pull_o && !scl_pull_o && !done_o));
endmodule

bind twi_unstick twi_unstick_chk #(
  .PRESC (PRESC),
  .LOW_T (LOW_T),
  .SU_T  (SU_T),
  .BUF_T (BUF_T)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/twi_unstick_bench.sv
`timescale 1ns/1ps
module twi_unstick_bench;
  localparam int PRESC = 2, LOW_T = 3, HIGH_T = 3, SU_T = 4, BUF_T = 3, HD_T = 2, MAXP = 9;
  localparam int L_CYC   = LOW_T * PRESC;
  localparam int H_CYC   = HIGH_T * PRESC;
  localparam int PRE_CYC = ((SU_T > BUF_T) ? SU_T : BUF_T) * PRESC;
  localparam int HD_CYC  = HD_T * PRESC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_pull, sda_pull, done, fail;
  logic scl_line, sda_line;

  int checks = 0;
  int errors = 0;

  int release_at = 0;
  int rises = 0;
  int stretch_left = 0;
  bit seen_low = 0;
  logic prev_scl = 1'b1;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_pull && !(stretch_left > 0);
  assign sda_line = !sda_pull && !(rises < release_at);

  // slave model, updated away from the active edge
  always @(negedge clk) begin
    if (scl_pull) seen_low <= 1'b1;
    if (stretch_left > 0 && !scl_pull && seen_low) stretch_left <= stretch_left - 1;
    if (scl_line && !prev_scl) rises <= rises + 1;
    prev_scl <= scl_line;
  end

  twi_unstick #(
    .PRESC(PRESC), .LOW_T(LOW_T), .HIGH_T(HIGH_T), .SU_T(SU_T),
    .BUF_T(BUF_T), .HD_T(HD_T), .MAX_PULSES(MAXP)
  ) u_twi_unstick (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .done_o(done), .fail_o(fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rel: high phase in which slave frees SDA; dly: stretch of first high phase; inj: cycle to pulse start_i (0 none)
  task automatic run(input int rel, input int dly, input int inj);
    int n, lows, bad_low, cur_low, sda_rise_n, exp_p, exp_t;
    bit prev_pull, exp_done;
    exp_p    = (rel < 1) ? 1 : rel;
    exp_done = (exp_p <= MAXP);
    if (!exp_done) exp_p = MAXP;
    exp_t = exp_p * (L_CYC + H_CYC) + dly + (exp_done ? (PRE_CYC + HD_CYC) : 0);

    @(negedge clk);
    release_at = rel; rises = 0; seen_low = 0;
    stretch_left = (dly > 0) ? dly + 1 : 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(scl_pull && !sda_pull && !done && !fail, "R2/R10 start state", {scl_pull, sda_pull, done, fail}, 4'b1000);
    lows = 0; bad_low = 0; cur_low = 0; prev_pull = 1'b0; sda_rise_n = 0;
    while (!done && !fail && n < 4000) begin
      if (scl_pull && !prev_pull) lows++;
      if (scl_pull) cur_low++;
      else begin
        if (prev_pull && cur_low != L_CYC) bad_low++;
        cur_low = 0;
      end
      if (sda_pull && sda_rise_n == 0) sda_rise_n = n;
      prev_pull = scl_pull;
      @(negedge clk);
      n++;
      start = (n == inj);
    end
    start = 1'b0;
    check(n == exp_t + 1, "R4/R5/R6/R7/R8 sequence length", n - 1, exp_t);
    check(lows == exp_p, "R5 pulse count", lows, exp_p);
    check(bad_low == 0, "R3 low phase width", bad_low, 0);
    if (exp_done) begin
      check(done && !fail, "R6 done flag", {done, fail}, 2'b10);
      check(n - sda_rise_n == HD_CYC, "R6 start hold", n - sda_rise_n, HD_CYC);
    end else begin
      check(fail && !done && sda_rise_n == 0, "R7 fail without start", {fail, done}, 2'b10);
    end
    repeat (7) @(negedge clk);
    if (exp_done)
      check(sda_pull && !scl_pull && done, "R6 bus held after start", {sda_pull, scl_pull}, 2'b10);
    else
      check(!sda_pull && !scl_pull && fail, "R7 lines released", {sda_pull, scl_pull}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_pull && !sda_pull && !done && !fail, "R1 reset state", {scl_pull, sda_pull, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_pull && !sda_pull && !done && !fail, "R1 idle after reset", {scl_pull, sda_pull, done, fail}, 0);
    for (int r = 0; r <= MAXP + 2; r++) run(r, 0, 0);
    run(3, 5, 0);   // R4 stretch of first high phase
    run(1, 9, 0);   // R4 stretch on the releasing phase
    run(4, 0, 20);  // R8 start during clocking
    run(2, 0, 27);  // R8 start during the START setup window
    run(MAXP + 1, 0, 40); // R8 start on a failing run
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule